// File: doc/BRIEF.md
# Interline CCD Drive Timing Generator

The block derives every digital timing signal that a progressive-scan interline CCD sensor needs from one pixel-rate clock. A free-running pixel counter splits each line into blanking, dummy, front optical-black, effective and rear optical-black intervals. A line counter then arranges those lines into frames. From the two counts the block forms horizontal and vertical sync, the four vertical transfer phase controls, two readout gate pulses, an electronic-shutter substrate pulse, and pixel-class flags that tell a downstream capture stage which samples carry image data.

There are two operating modes. In full progressive mode a frame is 800 lines and every row is read out. In high-speed mode a frame is 400 lines: only the first readout gate fires, and the vertical register is clocked twice per line so that two sensor rows are swept per output line. A shutter count sets, in whole lines, how long charge is stored before readout. The mode and shutter inputs take effect only at a frame boundary.

The block has no data stream of its own, so no valid/ready handshake is involved and nothing can apply back-pressure. All inputs and outputs are plain level signals, and the outputs follow the pixel clock without stalling.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every output is at its idle level from that edge on: `hd`, `vd`, `frame_start`, `rd_gate1`, `rd_gate2`, `sub_pulse`, `hshift_en` and `pixel_valid` are 0, `pix_class` is 0, and {`v1`,`v2a`,`v2b`,`v3`} is 1100. The first cycle after release shows line 0, pixel 0.
- R2: A line lasts H_BLANK+N_DUMMY+N_FRONT_OB+N_EFFECTIVE+N_REAR_OB clocks (default 1197). `hd` is high during the first HD_WIDTH pixels of every line.
- R3: Within a line, `pix_class` follows a fixed order. It is 0 (blank) for H_BLANK pixels, then 1 (dummy) for N_DUMMY, then 2 (optical black) for N_FRONT_OB, then 3 (effective) for N_EFFECTIVE, then 2 for N_REAR_OB. `hshift_en` is high exactly when the class is not blank.
- R4: A frame is PROG_LINES lines (default 800) in progressive mode (`mode_fast`=0) and PROG_LINES/2 lines in high-speed mode. `vd` is high for all of line 0. `frame_start` is high for exactly one clock, at line 0 pixel 0.
- R5: `pixel_valid` is high exactly on the effective pixels of lines 1 to N-1, where N is the frame length.
- R6: On line 0, the readout pulse covers pixels RD_OFF to RD_OFF+RD_WIDTH-1, with RD_OFF=(RD_WINDOW-RD_WIDTH)/2 (default 284 to 319). `rd_gate1` pulses in both modes. `rd_gate2` pulses only in progressive mode.
- R7: The phase pattern {`v1`,`v2a`,`v2b`,`v3`} advances through 1100, 0110, 0011, 1001 and back to 1100. It steps at the edge that ends pixel VSTEP_PIX of every line except line 0. In high-speed mode it steps again at pixel VSTEP2_PIX. It never changes at any other time.
- R8: With latched shutter count S, `sub_pulse` is high on pixels SUB_PIX to SUB_PIX+SUB_WIDTH-1 of each line L with 1 ≤ L and L+S < N. No other line carries the pulse, so a larger S stores charge for more lines.
- R9: `mode_fast` and `shutter_lines` are sampled only while `rst` is high and at the last clock of a frame. A change inside a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_fast | input | 1 | 0 selects progressive mode, 1 selects high-speed mode |
| shutter_lines | input | LINE_W | Shutter count S, in lines |
| hd | output | 1 | Horizontal sync |
| vd | output | 1 | Vertical sync (line 0) |
| frame_start | output | 1 | One-clock strobe at line 0, pixel 0 |
| v1 | output | 1 | Vertical phase 1 control |
| v2a | output | 1 | Vertical phase 2A control |
| v2b | output | 1 | Vertical phase 2B control |
| v3 | output | 1 | Vertical phase 3 control |
| rd_gate1 | output | 1 | Readout gate pulse combined onto V2A |
| rd_gate2 | output | 1 | Readout gate pulse combined onto V2B |
| sub_pulse | output | 1 | Electronic-shutter substrate pulse |
| hshift_en | output | 1 | Horizontal shift and reset-gate clock enable |
| pix_class | output | 2 | 0 blank, 1 dummy, 2 optical black, 3 effective |
| pixel_valid | output | 1 | Effective pixel of a read-out line |

## Verification
A wrong pixel count shows up within the same line: the class boundaries, the sync width or the readout pulse land on the wrong pixel. A wrong line count or a mis-latched mode shows up at the next frame boundary, as a frame that is too long or too short and a wrong number of valid pixels. A phase index that slips or steps at the wrong moment breaks the four-state order of the vertical phases within one line. A bad shutter comparison changes the number of substrate pulses per frame, so it is visible by the end of that frame.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [1:0] {
    PX_BLANK = 2'd0,
    PX_DUMMY = 2'd1,
    PX_OB    = 2'd2,
    PX_EFF   = 2'd3
  } pix_class_e;

  // Four-state vertical phase pattern, bit order {v1, v2a, v2b, v3}
  function automatic logic [3:0] vphase_pattern(input logic [1:0] idx);
    logic [3:0] p;
    case (idx)
      2'd0:    p = 4'b1100;
      2'd1:    p = 4'b0110;
      2'd2:    p = 4'b0011;
      default: p = 4'b1001;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ccd_htiming.sv
module ccd_htiming
  import ccd_tg_pkg::*;
#(
  parameter int H_BLANK     = 91,
  parameter int N_DUMMY     = 29,
  parameter int N_FRONT_OB  = 3,
  parameter int N_EFFECTIVE = 1034,
  parameter int N_REAR_OB   = 40,
  parameter int HD_WIDTH    = 5,
  localparam int LINE_CLKS  = H_BLANK + N_DUMMY + N_FRONT_OB + N_EFFECTIVE + N_REAR_OB,
  localparam int PIX_W      = $clog2(LINE_CLKS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             run,
  output logic [PIX_W-1:0] pix,
  output logic             line_end,
  output pix_class_e       pclass,
  output logic             hd
);

  localparam logic [PIX_W-1:0] P_DUMMY = PIX_W'(H_BLANK);
  localparam logic [PIX_W-1:0] P_FOB   = PIX_W'(H_BLANK + N_DUMMY);
  localparam logic [PIX_W-1:0] P_EFF   = PIX_W'(H_BLANK + N_DUMMY + N_FRONT_OB);
  localparam logic [PIX_W-1:0] P_ROB   = PIX_W'(H_BLANK + N_DUMMY + N_FRONT_OB + N_EFFECTIVE);
  localparam logic [PIX_W-1:0] P_LAST  = PIX_W'(LINE_CLKS - 1);
  localparam logic [PIX_W-1:0] P_HDEND = PIX_W'(HD_WIDTH);

  // run holds the counter at pixel 0 for one cycle after reset release
  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      pix <= '0;
    end else if (!run) begin
      run <= 1'b1;
    end else if (pix == P_LAST) begin
      pix <= '0;
    end else begin
      pix <= pix + 1'b1;
    end
  end

  assign line_end = run && (pix == P_LAST);
  assign hd       = run && (pix < P_HDEND);

  always_comb begin
    if (!run || pix < P_DUMMY) pclass = PX_BLANK;
    else if (pix < P_FOB)      pclass = PX_DUMMY;
    else if (pix < P_EFF)      pclass = PX_OB;
    else if (pix < P_ROB)      pclass = PX_EFF;
    else                       pclass = PX_OB;
  end

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (pix == '0) && hd);

  assert_dummy_then_black_R3: assert property (@(posedge clk) disable iff (rst)
    (run && pclass == PX_DUMMY) |=> (pclass == PX_DUMMY || pclass == PX_OB));

  assert_eff_then_black_R3: assert property (@(posedge clk) disable iff (rst)
    (run && pclass == PX_EFF) |=> (pclass == PX_EFF || pclass == PX_OB));

endmodule

// File: rtl/ccd_vtiming.sv
module ccd_vtiming #(
  parameter int PROG_LINES = 800,
  parameter int LINE_W     = 10,
  parameter int PIX_W      = 11,
  parameter int VSTEP_PIX  = 40,
  parameter int VSTEP2_PIX = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PIX_W-1:0]  pix,
  input  logic              line_end,
  input  logic              mode_fast,
  input  logic [LINE_W-1:0] shutter_lines,
  output logic [LINE_W-1:0] line,
  output logic              fast_lat,
  output logic [LINE_W-1:0] shut_lat,
  output logic              vd,
  output logic              frame_start,
  output logic              readout_line,
  output logic [3:0]        vphase
);

  localparam logic [LINE_W-1:0] PROG_LAST = LINE_W'(PROG_LINES - 1);
  localparam logic [LINE_W-1:0] FAST_LAST = LINE_W'(PROG_LINES / 2 - 1);
  localparam logic [PIX_W-1:0]  P_STEP1   = PIX_W'(VSTEP_PIX);
  localparam logic [PIX_W-1:0]  P_STEP2   = PIX_W'(VSTEP2_PIX);

  logic       frame_end;
  logic       step;
  logic [1:0] ph_idx;

  assign frame_end = line_end && (line == (fast_lat ? FAST_LAST : PROG_LAST));
  assign step = run && (line != '0) &&
                ((pix == P_STEP1) || (fast_lat && pix == P_STEP2));

  always_ff @(posedge clk) begin
    if (rst) begin
      line     <= '0;
      ph_idx   <= 2'd0;
      fast_lat <= mode_fast;
      shut_lat <= shutter_lines;
    end else begin
      if (line_end) line <= frame_end ? '0 : line + 1'b1;
      if (frame_end) begin
        fast_lat <= mode_fast;
        shut_lat <= shutter_lines;
      end
      if (step) ph_idx <= ph_idx + 2'd1;
    end
  end

  assign readout_line = run && (line == '0);
  assign vd           = readout_line;
  assign frame_start  = readout_line && (pix == '0);
  assign vphase       = ccd_tg_pkg::vphase_pattern(ph_idx);

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_start) |-> ($stable(fast_lat) && $stable(shut_lat)));

  assert_phase_step_time_R7: assert property (@(posedge clk) disable iff (rst)
    (run && !$stable(vphase)) |->
      ($past(line) != '0) &&
      (($past(pix) == P_STEP1) || (fast_lat && $past(pix) == P_STEP2)));

endmodule

// File: rtl/ccd_drive.sv
module ccd_drive
  import ccd_tg_pkg::*;
#(
  parameter int PROG_LINES = 800,
  parameter int LINE_W     = 10,
  parameter int PIX_W      = 11,
  parameter int RD_WINDOW  = 604,
  parameter int RD_WIDTH   = 36,
  parameter int SUB_PIX    = 10,
  parameter int SUB_WIDTH  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic              readout_line,
  input  logic              fast_lat,
  input  logic [LINE_W-1:0] shut_lat,
  input  pix_class_e        pclass,
  output logic              rd_gate1,
  output logic              rd_gate2,
  output logic              sub_pulse,
  output logic              pixel_valid
);

  localparam int RD_OFF = (RD_WINDOW - RD_WIDTH) / 2;
  localparam logic [PIX_W-1:0]  P_RD_LO  = PIX_W'(RD_OFF);
  localparam logic [PIX_W-1:0]  P_RD_HI  = PIX_W'(RD_OFF + RD_WIDTH);
  localparam logic [PIX_W-1:0]  P_SUB_LO = PIX_W'(SUB_PIX);
  localparam logic [PIX_W-1:0]  P_SUB_HI = PIX_W'(SUB_PIX + SUB_WIDTH);
  localparam logic [LINE_W:0]   N_PROG   = (LINE_W + 1)'(PROG_LINES);
  localparam logic [LINE_W:0]   N_FAST   = (LINE_W + 1)'(PROG_LINES / 2);

  logic [LINE_W:0] line_plus_s;
  logic            sub_line;
  logic            rd_window;

  assign line_plus_s = {1'b0, line} + {1'b0, shut_lat};
  assign sub_line    = (line != '0) && (line_plus_s < (fast_lat ? N_FAST : N_PROG));
  assign rd_window   = readout_line && (pix >= P_RD_LO) && (pix < P_RD_HI);

  assign rd_gate1    = rd_window;
  assign rd_gate2    = rd_window && !fast_lat;
  assign sub_pulse   = run && sub_line && (pix >= P_SUB_LO) && (pix < P_SUB_HI);
  assign pixel_valid = run && (line != '0) && (pclass == PX_EFF);

  assert_gate2_prog_only_R6: assert property (@(posedge clk) disable iff (rst)
    rd_gate2 |-> (rd_gate1 && !fast_lat));

  assert_sub_in_blank_R8: assert property (@(posedge clk) disable iff (rst)
    sub_pulse |-> (pclass == PX_BLANK && !readout_line));

  assert_valid_effective_R5: assert property (@(posedge clk) disable iff (rst)
    pixel_valid |-> (pclass == PX_EFF && !readout_line));

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int H_BLANK     = 91,
  parameter int N_DUMMY     = 29,
  parameter int N_FRONT_OB  = 3,
  parameter int N_EFFECTIVE = 1034,
  parameter int N_REAR_OB   = 40,
  parameter int HD_WIDTH    = 5,
  parameter int PROG_LINES  = 800,
  parameter int VSTEP_PIX   = 40,
  parameter int VSTEP2_PIX  = 60,
  parameter int RD_WINDOW   = 604,
  parameter int RD_WIDTH    = 36,
  parameter int SUB_PIX     = 10,
  parameter int SUB_WIDTH   = 20,
  localparam int LINE_CLKS  = H_BLANK + N_DUMMY + N_FRONT_OB + N_EFFECTIVE + N_REAR_OB,
  localparam int PIX_W      = $clog2(LINE_CLKS),
  localparam int LINE_W     = $clog2(PROG_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_fast,
  input  logic [LINE_W-1:0] shutter_lines,
  output logic              hd,
  output logic              vd,
  output logic              frame_start,
  output logic              v1,
  output logic              v2a,
  output logic              v2b,
  output logic              v3,
  output logic              rd_gate1,
  output logic              rd_gate2,
  output logic              sub_pulse,
  output logic              hshift_en,
  output logic [1:0]        pix_class,
  output logic              pixel_valid
);

  logic              run;
  logic [PIX_W-1:0]  pix;
  logic              line_end;
  pix_class_e        pclass;
  logic [LINE_W-1:0] line;
  logic              fast_lat;
  logic [LINE_W-1:0] shut_lat;
  logic              readout_line;
  logic [3:0]        vphase;

  ccd_htiming #(
    .H_BLANK(H_BLANK), .N_DUMMY(N_DUMMY), .N_FRONT_OB(N_FRONT_OB),
    .N_EFFECTIVE(N_EFFECTIVE), .N_REAR_OB(N_REAR_OB), .HD_WIDTH(HD_WIDTH)
  ) u_h (
    .clk(clk), .rst(rst), .run(run), .pix(pix),
    .line_end(line_end), .pclass(pclass), .hd(hd)
  );

  ccd_vtiming #(
    .PROG_LINES(PROG_LINES), .LINE_W(LINE_W), .PIX_W(PIX_W),
    .VSTEP_PIX(VSTEP_PIX), .VSTEP2_PIX(VSTEP2_PIX)
  ) u_v (
    .clk(clk), .rst(rst), .run(run), .pix(pix), .line_end(line_end),
    .mode_fast(mode_fast), .shutter_lines(shutter_lines),
    .line(line), .fast_lat(fast_lat), .shut_lat(shut_lat),
    .vd(vd), .frame_start(frame_start), .readout_line(readout_line),
    .vphase(vphase)
  );

  ccd_drive #(
    .PROG_LINES(PROG_LINES), .LINE_W(LINE_W), .PIX_W(PIX_W),
    .RD_WINDOW(RD_WINDOW), .RD_WIDTH(RD_WIDTH),
    .SUB_PIX(SUB_PIX), .SUB_WIDTH(SUB_WIDTH)
  ) u_d (
    .clk(clk), .rst(rst), .run(run), .pix(pix), .line(line),
    .readout_line(readout_line), .fast_lat(fast_lat), .shut_lat(shut_lat),
    .pclass(pclass), .rd_gate1(rd_gate1), .rd_gate2(rd_gate2),
    .sub_pulse(sub_pulse), .pixel_valid(pixel_valid)
  );

  assign {v1, v2a, v2b, v3} = vphase;
  assign pix_class = pclass;
  assign hshift_en = run && (pclass != PX_BLANK);

  assert_no_phase_move_in_readout_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_gate1 && $past(rd_gate1)) |-> $stable(vphase));

  assert_shift_outside_blank_R3: assert property (@(posedge clk) disable iff (rst)
    hshift_en |-> !sub_pulse);

endmodule

// File: tb/ccd_timing_gen_bench.sv
module ccd_timing_gen_bench;

  // Scaled geometry: line = 8+3+2+10+4 = 27 clocks, 8 or 4 lines per frame
  localparam int HB = 8, ND = 3, NF = 2, NE = 10, NR = 4;
  localparam int LCLK = HB + ND + NF + NE + NR;
  localparam int PLINES = 8;
  localparam int LW = $clog2(PLINES);
  localparam int WD_LIMIT = 20000;

  // {mode, shutter, clocks, valid, gate1, gate2, sub clocks, phase steps}
  localparam int NV = 6;
  localparam int VEC [NV][8] = '{
    '{0, 0, 216, 70, 4, 4, 14, 7},
    '{0, 3, 216, 70, 4, 4,  8, 7},
    '{0, 7, 216, 70, 4, 4,  0, 7},
    '{1, 1, 108, 30, 4, 0,  4, 6},
    '{1, 5, 108, 30, 4, 0,  0, 6},
    '{0, 1, 216, 70, 4, 4, 12, 7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_fast = 1'b0;
  logic [LW-1:0] shutter_lines = '0;
  logic hd, vd, frame_start, v1, v2a, v2b, v3;
  logic rd_gate1, rd_gate2, sub_pulse, hshift_en, pixel_valid;
  logic [1:0] pix_class;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ccd_timing_gen #(
    .H_BLANK(HB), .N_DUMMY(ND), .N_FRONT_OB(NF), .N_EFFECTIVE(NE),
    .N_REAR_OB(NR), .HD_WIDTH(2), .PROG_LINES(PLINES),
    .VSTEP_PIX(5), .VSTEP2_PIX(6), .RD_WINDOW(12), .RD_WIDTH(4),
    .SUB_PIX(2), .SUB_WIDTH(2)
  ) u_ccd_timing_gen (
    .clk(clk), .rst(rst), .mode_fast(mode_fast), .shutter_lines(shutter_lines),
    .hd(hd), .vd(vd), .frame_start(frame_start),
    .v1(v1), .v2a(v2a), .v2b(v2b), .v3(v3),
    .rd_gate1(rd_gate1), .rd_gate2(rd_gate2), .sub_pulse(sub_pulse),
    .hshift_en(hshift_en), .pix_class(pix_class), .pixel_valid(pixel_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] next_pat(input logic [3:0] p);
    case (p)
      4'b1100: return 4'b0110;
      4'b0110: return 4'b0011;
      4'b0011: return 4'b1001;
      default: return 4'b1100;
    endcase
  endfunction

  function automatic int exp_class(input int px);
    if (px < HB) return 0;
    if (px < HB + ND) return 1;
    if (px < HB + ND + NF) return 2;
    if (px < HB + ND + NF + NE) return 3;
    return 2;
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R1 hd"}, hd, 0);
    chk({tag, " R1 vd"}, vd, 0);
    chk({tag, " R1 frame_start"}, frame_start, 0);
    chk({tag, " R1 rd_gate1"}, rd_gate1, 0);
    chk({tag, " R1 rd_gate2"}, rd_gate2, 0);
    chk({tag, " R1 sub_pulse"}, sub_pulse, 0);
    chk({tag, " R1 hshift_en"}, hshift_en, 0);
    chk({tag, " R1 pix_class"}, pix_class, 0);
    chk({tag, " R1 pixel_valid"}, pixel_valid, 0);
    chk({tag, " R1 vphase"}, {v1, v2a, v2b, v3}, 4'b1100);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int clocks, nvalid, ng1, ng2, nsub, steps, bad;
    logic [3:0] prev;

    rst = 1'b1;
    mode_fast = 1'(VEC[0][0]);
    shutter_lines = LW'(VEC[0][1]);
    repeat (3) @(negedge clk);
    check_idle("power-up");

    // Directed walk over lines 0 and 1 of a progressive frame, shutter 0
    rst = 1'b0;
    for (int k = 0; k < 2 * LCLK; k++) begin
      int ln, px, ecls;
      @(negedge clk);
      ln = k / LCLK;
      px = k % LCLK;
      ecls = exp_class(px);
      chk($sformatf("R2 hd line%0d pix%0d", ln, px), hd, (px < 2) ? 1 : 0);
      chk($sformatf("R3 class line%0d pix%0d", ln, px), pix_class, ecls);
      chk($sformatf("R3 hshift line%0d pix%0d", ln, px), hshift_en, (ecls != 0) ? 1 : 0);
      chk($sformatf("R4 vd line%0d pix%0d", ln, px), vd, (ln == 0) ? 1 : 0);
      chk($sformatf("R4 frame_start line%0d pix%0d", ln, px), frame_start, (k == 0) ? 1 : 0);
      chk($sformatf("R6 gate1 line%0d pix%0d", ln, px), rd_gate1,
          (ln == 0 && px >= 4 && px < 8) ? 1 : 0);
      chk($sformatf("R6 gate2 line%0d pix%0d", ln, px), rd_gate2,
          (ln == 0 && px >= 4 && px < 8) ? 1 : 0);
      chk($sformatf("R8 sub line%0d pix%0d", ln, px), sub_pulse,
          (ln == 1 && px >= 2 && px < 4) ? 1 : 0);
      chk($sformatf("R5 valid line%0d pix%0d", ln, px), pixel_valid,
          (ln == 1 && ecls == 3) ? 1 : 0);
      chk($sformatf("R7 vphase line%0d pix%0d", ln, px), {v1, v2a, v2b, v3},
          (ln == 1 && px >= 6) ? 4'b0110 : 4'b1100);
    end

    // Reset in mid-frame returns every output to idle
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_idle("mid-frame reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1 R4 first cycle after release strobes frame_start", frame_start, 1);

    // Table walk: inputs for the next frame change right after each strobe
    for (int i = 0; i < NV; i++) begin
      int nx;
      nx = (i + 1 < NV) ? i + 1 : i;
      mode_fast = 1'(VEC[nx][0]);
      shutter_lines = LW'(VEC[nx][1]);
      clocks = 0; nvalid = 0; ng1 = 0; ng2 = 0; nsub = 0; steps = 0; bad = 0;
      prev = {v1, v2a, v2b, v3};
      do begin
        clocks++;
        nvalid += int'(pixel_valid);
        ng1 += int'(rd_gate1);
        ng2 += int'(rd_gate2);
        nsub += int'(sub_pulse);
        if ({v1, v2a, v2b, v3} != prev) begin
          steps++;
          if ({v1, v2a, v2b, v3} != next_pat(prev)) bad++;
          prev = {v1, v2a, v2b, v3};
        end
        @(negedge clk);
      end while (!frame_start);
      chk($sformatf("R4 R9 frame length vec%0d", i), clocks, VEC[i][2]);
      chk($sformatf("R5 valid count vec%0d", i), nvalid, VEC[i][3]);
      chk($sformatf("R6 gate1 clocks vec%0d", i), ng1, VEC[i][4]);
      chk($sformatf("R6 gate2 clocks vec%0d", i), ng2, VEC[i][5]);
      chk($sformatf("R8 sub clocks vec%0d", i), nsub, VEC[i][6]);
      chk($sformatf("R7 phase steps vec%0d", i), steps, VEC[i][7]);
      chk($sformatf("R7 phase order vec%0d", i), bad, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule